// File: doc/BRIEF.md
# Serial Gain and Bias Control Register

This block receives an 8-bit control word over a three-wire serial link made of a serial clock, an active-low load enable and a data line. It brings all three into the system clock domain through two-flop synchronizers and detects their edges there. While the load enable is low, each rising edge of the serial clock shifts one data bit into an internal shift register, most significant bit first. When the load enable returns high, the word is checked and committed to an output latch. The two top bits of the latch select a bias preset and the six low bits select a gain step.

Only gain codes from 1 to 60 are accepted. A commit that carries any other code raises a one-cycle error pulse and leaves the latch as it was. A valid flag tracks whether any word has been accepted since reset. The latched fields drive the analog path, which lies outside this block.

Two asynchronous pins set the power state. The sleep pin is active low and forces full power-down. The transmit-enable pin allows transmission. The active state needs sleep high, transmit-enable high and an accepted word, so the output stage stays off until a gain has been programmed.

Top module: `gain_bias_ctrl`

## Requirements
- R1: While `den_i` is low, each rising edge of `sclk_i` shifts `sdata_i` into an 8-bit register, first bit ending up in bit 7. When more than 8 bits are shifted, only the last 8 are kept.
- R2: Rising edges of `sclk_i` while `den_i` is high leave the shift register unchanged.
- R3: A rising edge of `den_i` commits the shifted word: `cur_level_o` = bits [7:6] and `gain_code_o` = bits [5:0]. The new values appear 3 system clocks after the edge reaches the input. The latch holds its value while a load is in progress.
- R4: A commit whose bits [5:0] are 0 or greater than 60 leaves `cur_level_o` and `gain_code_o` unchanged. It pulses `cmd_err_o` high for exactly one cycle, at the cycle an accepted word would have appeared.
- R5: `word_valid_o` is 0 after reset. It sets on the first accepted commit and stays set; rejected commits do not clear it.
- R6: After reset, `cur_level_o` = 0, `gain_code_o` = 0, `word_valid_o` = 0, `cmd_err_o` = 0 and `active_o` = 0.
- R7: `sleep_ni` low gives `state_o` = 2'b00 (power-down) and `active_o` = 0, whatever the other inputs are. This path is combinational from the pin.
- R8: With `sleep_ni` high, `state_o` = 2'b10 and `active_o` = 1 only when `txen_i` is high and `word_valid_o` is set. Otherwise `state_o` = 2'b01 (transmit off) and `active_o` = 0.
- R9: The boundary gain codes 1 and 60 are accepted with any current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| den_i | input | 1 | Load enable, low while shifting, rising edge commits |
| sdata_i | input | 1 | Serial data, most significant bit first |
| txen_i | input | 1 | Transmit enable, asynchronous |
| sleep_ni | input | 1 | Power-down request, active low, asynchronous |
| cur_level_o | output | 2 | Committed current level, 3 highest |
| gain_code_o | output | 6 | Committed gain code, 1..60 |
| word_valid_o | output | 1 | An accepted word has been committed since reset |
| cmd_err_o | output | 1 | One-cycle pulse on a rejected commit |
| state_o | output | 2 | Power state: 00 sleep, 01 transmit off, 10 active |
| active_o | output | 1 | Output stage enabled |

## Verification
A committed word and the error pulse are due exactly 3 system clocks after the load enable rises at the input: two synchronizer stages, then the edge-detected commit registering into the latch. The driver records the cycle on which it raises the load enable and queues the expected fields with a due cycle 3 later. The monitor compares them on the falling clock edge of exactly that cycle, so a commit one cycle late or one cycle early is reported. The power-state outputs have no register in their path, so they are checked 1 ns after the bench changes `txen_i` or `sleep_ni`. The latch hold is checked just before each commit.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned CL_W     = 2;
  localparam int unsigned GAIN_W   = WORD_W - CL_W;
  localparam int unsigned GAIN_MIN = 1;
  localparam int unsigned GAIN_MAX = 60;
  localparam int unsigned SYNC_STG = 2;

  typedef enum logic [1:0] {
    PWR_SLEEP  = 2'b00,
    PWR_TXOFF  = 2'b01,
    PWR_ACTIVE = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/gbc_sync.sv
module gbc_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[s-1].q;
      end
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/gbc_shift.sv
module gbc_shift #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              den_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic              sclk_q;
  logic              den_q;
  logic [WORD_W-1:0] sr_q;
  logic              sclk_rise;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign commit_o  = den_i & ~den_q;
  assign word_o    = sr_q;

  // den_q resets high: the idle level of the load enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      den_q  <= 1'b1;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      den_q  <= den_i;
      if (sclk_rise && !den_i) sr_q <= {sr_q[WORD_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/gbc_latch.sv
module gbc_latch #(
  parameter int unsigned CL_W     = 2,
  parameter int unsigned GAIN_W   = 6,
  parameter int unsigned GAIN_MIN = 1,
  parameter int unsigned GAIN_MAX = 60
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  logic [CL_W+GAIN_W-1:0] word_i,
  output logic [CL_W-1:0]        cur_level_o,
  output logic [GAIN_W-1:0]      gain_code_o,
  output logic                   word_valid_o,
  output logic                   cmd_err_o
);
  localparam logic [GAIN_W-1:0] LO = GAIN_W'(GAIN_MIN);
  localparam logic [GAIN_W-1:0] HI = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] gain_in;
  logic              code_ok;

  assign gain_in = word_i[GAIN_W-1:0];
  assign code_ok = (gain_in >= LO) && (gain_in <= HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_level_o  <= '0;
      gain_code_o  <= '0;
      word_valid_o <= 1'b0;
      cmd_err_o    <= 1'b0;
    end else begin
      cmd_err_o <= commit_i & ~code_ok;
      if (commit_i && code_ok) begin
        cur_level_o  <= word_i[CL_W+GAIN_W-1:GAIN_W];
        gain_code_o  <= gain_in;
        word_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gain_bias_ctrl.sv
module gain_bias_ctrl
  import gbc_pkg::*;
#(
  parameter int unsigned P_CL_W     = CL_W,
  parameter int unsigned P_GAIN_W   = GAIN_W,
  parameter int unsigned P_GAIN_MIN = GAIN_MIN,
  parameter int unsigned P_GAIN_MAX = GAIN_MAX,
  parameter int unsigned P_SYNC_STG = SYNC_STG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                den_i,
  input  logic                sdata_i,
  input  logic                txen_i,
  input  logic                sleep_ni,
  output logic [P_CL_W-1:0]   cur_level_o,
  output logic [P_GAIN_W-1:0] gain_code_o,
  output logic                word_valid_o,
  output logic                cmd_err_o,
  output logic [1:0]          state_o,
  output logic                active_o
);
  localparam int unsigned WW = P_CL_W + P_GAIN_W;

  logic [2:0]    ser_s;
  logic [WW-1:0] word;
  logic          commit;
  pwr_state_e    pwr;

  // bit order {sclk, den, sdata}; den idles high
  gbc_sync #(.W(3), .STAGES(P_SYNC_STG), .RST_VAL(3'b010)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, den_i, sdata_i}),
    .q_o    (ser_s)
  );

  gbc_shift #(.WORD_W(WW)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (ser_s[2]),
    .den_i    (ser_s[1]),
    .sdata_i  (ser_s[0]),
    .word_o   (word),
    .commit_o (commit)
  );

  gbc_latch #(
    .CL_W(P_CL_W), .GAIN_W(P_GAIN_W), .GAIN_MIN(P_GAIN_MIN), .GAIN_MAX(P_GAIN_MAX)
  ) i_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .word_i       (word),
    .cur_level_o  (cur_level_o),
    .gain_code_o  (gain_code_o),
    .word_valid_o (word_valid_o),
    .cmd_err_o    (cmd_err_o)
  );

  // pin-driven, no register on this path
  always_comb begin
    if (!sleep_ni)                   pwr = PWR_SLEEP;
    else if (txen_i && word_valid_o) pwr = PWR_ACTIVE;
    else                             pwr = PWR_TXOFF;
  end

  assign state_o  = pwr;
  assign active_o = (pwr == PWR_ACTIVE);
endmodule

// File: rtl/gain_bias_ctrl_chk.sv
module gain_bias_ctrl_chk
  import gbc_pkg::*;
#(
  parameter int unsigned P_CL_W     = CL_W,
  parameter int unsigned P_GAIN_W   = GAIN_W,
  parameter int unsigned P_GAIN_MIN = GAIN_MIN,
  parameter int unsigned P_GAIN_MAX = GAIN_MAX
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                txen_i,
  input logic                sleep_ni,
  input logic                commit_i,
  input logic [P_CL_W-1:0]   cur_level_o,
  input logic [P_GAIN_W-1:0] gain_code_o,
  input logic                word_valid_o,
  input logic                cmd_err_o,
  input logic [1:0]          state_o,
  input logic                active_o
);
  // R8
  active_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (sleep_ni && txen_i && word_valid_o));

  // R7
  sleep_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |-> (state_o == PWR_SLEEP && !active_o));

  // R5
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> word_valid_o);

  // R4
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $stable({cur_level_o, gain_code_o}));

  // R4
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> !cmd_err_o);

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({cur_level_o, gain_code_o}) |-> $past(commit_i));

  // R9
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (gain_code_o >= P_GAIN_W'(P_GAIN_MIN) &&
                      gain_code_o <= P_GAIN_W'(P_GAIN_MAX)));
endmodule

bind gain_bias_ctrl gain_bias_ctrl_chk #(
  .P_CL_W(P_CL_W), .P_GAIN_W(P_GAIN_W), .P_GAIN_MIN(P_GAIN_MIN), .P_GAIN_MAX(P_GAIN_MAX)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .txen_i       (txen_i),
  .sleep_ni     (sleep_ni),
  .commit_i     (commit),
  .cur_level_o  (cur_level_o),
  .gain_code_o  (gain_code_o),
  .word_valid_o (word_valid_o),
  .cmd_err_o    (cmd_err_o),
  .state_o      (state_o),
  .active_o     (active_o)
);

// File: tb/test_gain_bias_ctrl.sv
`timescale 1ns/1ps
module test_gain_bias_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rst_n, sclk, den, sdata, txen, sleep_n;
  logic [1:0] cur_level, state;
  logic [5:0] gain_code;
  logic       word_valid, cmd_err, active;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int         due;
    logic [1:0] cl;
    logic [5:0] gain;
    logic       valid;
    logic       err;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  exp_t item;

  logic [7:0] bench_sr = '0;
  logic [1:0] m_cl = '0;
  logic [5:0] m_gain = '0;
  logic       m_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gain_bias_ctrl i_gain_bias_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .den_i(den), .sdata_i(sdata),
    .txen_i(txen), .sleep_ni(sleep_n), .cur_level_o(cur_level), .gain_code_o(gain_code),
    .word_valid_o(word_valid), .cmd_err_o(cmd_err), .state_o(state), .active_o(active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare queued items exactly on their due cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      item = exp_q.pop_front();
      chk(item.req, "cur_level", int'(cur_level), int'(item.cl));
      chk(item.req, "gain_code", int'(gain_code), int'(item.gain));
      chk(item.req, "word_valid", int'(word_valid), int'(item.valid));
      chk(item.req, "cmd_err", int'(cmd_err), int'(item.err));
    end
  end

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      bench_sr = {bench_sr[6:0], bits[i]};
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic commit(input string req);
    exp_t e;
    logic ok;
    @(negedge clk);
    den = 1'b1;
    ok = (bench_sr[5:0] >= 6'd1) && (bench_sr[5:0] <= 6'd60);
    if (ok) begin
      m_cl = bench_sr[7:6];
      m_gain = bench_sr[5:0];
      m_valid = 1'b1;
    end
    e.due = cyc + LAT; e.cl = m_cl; e.gain = m_gain; e.valid = m_valid;
    e.err = !ok; e.req = req;
    exp_q.push_back(e);
    repeat (8) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] bits, input int n, input string req);
    @(negedge clk);
    den = 1'b0;
    repeat (HALF) @(negedge clk);
    shift_bits(bits, n);
    repeat (HALF) @(negedge clk);
    // R3 hold while loading
    chk("R3", "hold cur_level", int'(cur_level), int'(m_cl));
    chk("R3", "hold gain_code", int'(gain_code), int'(m_gain));
    commit(req);
  endtask

  task automatic pwr(input logic tx, input logic sl, input string req);
    logic [1:0] es;
    @(negedge clk);
    txen = tx;
    sleep_n = sl;
    #1;
    if (!sl) es = 2'b00;
    else if (tx && m_valid) es = 2'b10;
    else es = 2'b01;
    chk(req, "state", int'(state), int'(es));
    chk(req, "active", int'(active), int'(es == 2'b10));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; den = 1'b1; sdata = 1'b0; txen = 1'b1; sleep_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk("R6", "cur_level", int'(cur_level), 0);
    chk("R6", "gain_code", int'(gain_code), 0);
    chk("R6", "word_valid", int'(word_valid), 0);
    chk("R6", "cmd_err", int'(cmd_err), 0);
    chk("R6", "active", int'(active), 0);
    pwr(1'b1, 1'b1, "R8 no word yet");

    load(16'h0000, 8, "R4 code 0 rejected");
    pwr(1'b1, 1'b1, "R5 still no word");
    load(16'h00C5, 8, "R1 R3 R5 first word");
    pwr(1'b1, 1'b1, "R8 active");
    pwr(1'b0, 1'b1, "R8 txen low");
    pwr(1'b1, 1'b0, "R7 sleep");
    pwr(1'b0, 1'b0, "R7 sleep txen low");
    pwr(1'b1, 1'b1, "R8 back active");

    load(16'h007D, 8, "R4 code 61 rejected");
    pwr(1'b1, 1'b1, "R5 valid kept after reject");
    load(16'h003C, 8, "R9 code 60 level 0");
    load(16'h0081, 8, "R9 code 1 level 2");
    load(16'h00FF, 8, "R4 code 63 rejected");

    // R2: clocks with den high must not shift
    load(16'h00C5, 8, "R3 reload");
    for (int k = 0; k < 8; k++) begin
      sdata = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    @(negedge clk);
    den = 1'b0;
    repeat (8) @(negedge clk);
    commit("R2 ignored clocks");

    load(16'h0F2A, 12, "R1 last 8 of 12 bits");
    load(16'h0041, 8, "R1 R9 code 1 level 1");

    repeat (10) @(negedge clk);
    chk("R3", "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule